// File: doc/BRIEF.md
# Banked Indexed Register Port

This block gives a host a 16-bit, two-address window onto a set of register banks. Each bank holds sixteen 12-bit registers. One address holds the bank/index control word. The other address is the data port. The control word names the active bank and carries the index used for reads.

Reads and writes reach a register in different ways. A write to the data port carries its own target index in its top nibble. A read uses the read index stored in the control word, and that index can step forward by one after every data read. Software can therefore set a bank and starting index once, then stream reads out of consecutive registers.

Bank 0 holds the system registers. Its register 0 is a read-only interrupt status word, rebuilt every cycle from ten request lines. Bank 1 holds the blit engine's registers. Register 0 of bank 1 carries a start flag, which hardware clears when the engine reports completion. Bank 2 holds the cursor registers. Any bank number of `NUM_BANKS` or above has no registers behind it. The control word flags such a bank, and data-port traffic aimed at it has no effect.

Top module: `banked_reg_port`

## Requirements
- R1: After reset the control word reads 0 (bank 0, read index 0, auto-increment on). Every bank register reads 0 and `blitStart` is low.
- R2: A write to address 0 stores control bits 7:0 as the bank number, bits 11:8 as the read index and bit 12 as the no-increment flag. A read of address 0 returns those fields in the same positions, with bits 15:14 reading 0.
- R3: Control bit 13 reads 1 exactly when the stored bank number is `NUM_BANKS` or larger. The value written to bit 13 is ignored.
- R4: A write to address 1 in an existing bank stores bits 11:0 into the register whose index is given by bits 15:12. A read of address 1 returns the register at the current read index, zero-extended to 16 bits.
- R5: A read of address 1 with bit 12 clear advances the read index by one, wrapping from 15 to 0. With bit 12 set, the read index is unchanged.
- R6: When the selected bank does not exist, data-port writes change no register in any bank and data-port reads return 0.
- R7: Bank 0 register 0 reads as the status word, one cycle behind the request lines, where `irqReq[k-1]` is interrupt k. The bit layout is:
  - bit 0 is the OR of all ten lines;
  - bits 6:1 are interrupts 1 to 6;
  - bit 7 is the OR of interrupts 7 to 10;
  - bits 11:8 are interrupts 7 to 10;
  - bit 1 is the display source and bit 2 is the blit source.
- R8: Writes to bank 0 register 0 are ignored.
- R9: Bit 11 of bank 1 register 0 drives `blitStart`. A `blitDone` pulse clears only that bit. If a write to that register happens in the same cycle as `blitDone`, the written value takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (data reads advance the index) |
| hostAddr | input | 1 | 0 selects the control word, 1 the data port |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Read data for the addressed location, combinational |
| irqReq | input | 10 | Interrupt request lines, bit k-1 is interrupt k |
| blitDone | input | 1 | Completion pulse from the blit engine |
| blitStart | output | 1 | Start flag held in bank 1 register 0 |

## Verification
The bench drives reads through index 15 and checks that the index wraps to 0. A design without the wrap would stop at 15 or run into a wrong register. The bench writes to nonexistent banks numbered 3 and 0x81, then reads the same index from every real bank. A decoder that keeps only the low bank bits would corrupt bank 1 here.

The bench also checks that a write and a `blitDone` in the same cycle leave the start flag set, and that `blitDone` keeps the low control bits. Single interrupt patterns expose a status word with swapped or missing OR bits. A random mix of all host operations follows and is checked against a reference model kept in the bench.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int DATA_W    = 12;
  localparam int IDX_W     = 4;
  localparam int NUM_IDX   = 1 << IDX_W;
  localparam int BANKSEL_W = 8;
  localparam int HOST_W    = 16;
  localparam int NUM_IRQ   = 10;
  localparam int START_BIT = 11;

  // Control bits in the bank/index word
  localparam int RDIDX_LSB  = 8;
  localparam int NOINC_BIT  = 12;
  localparam int INVAL_BIT  = 13;

  typedef struct packed {
    logic                 dataWe;
    logic [IDX_W-1:0]     wrIdx;
    logic [DATA_W-1:0]    wrVal;
    logic [BANKSEL_W-1:0] bank;
    logic [IDX_W-1:0]     rdIdx;
    logic                 bankValid;
  } ctrlStrobe_t;
endpackage

// File: rtl/brp_ctrl.sv
module brp_ctrl
  import brp_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output ctrlStrobe_t       ctrlS,
  output logic [HOST_W-1:0] bankRegView,
  output logic              noInc
);
  logic [BANKSEL_W-1:0] bankQ;
  logic [IDX_W-1:0]     rdIdxQ;
  logic                 noIncQ;
  logic                 bankValid;
  logic                 ctrlWe;
  logic                 dataRe;

  assign ctrlWe    = hostWr && !hostAddr;
  assign dataRe    = hostRd && hostAddr;
  assign bankValid = bankQ < BANKSEL_W'(NUM_BANKS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= '0;
      rdIdxQ <= '0;
      noIncQ <= 1'b0;
    end else if (ctrlWe) begin
      bankQ  <= hostWdata[BANKSEL_W-1:0];
      rdIdxQ <= hostWdata[RDIDX_LSB +: IDX_W];
      noIncQ <= hostWdata[NOINC_BIT];
    end else if (dataRe && !noIncQ) begin
      rdIdxQ <= rdIdxQ + 1'b1;
    end
  end

  always_comb begin
    ctrlS.dataWe    = hostWr && hostAddr;
    ctrlS.wrIdx     = hostWdata[HOST_W-1 -: IDX_W];
    ctrlS.wrVal     = hostWdata[DATA_W-1:0];
    ctrlS.bank      = bankQ;
    ctrlS.rdIdx     = rdIdxQ;
    ctrlS.bankValid = bankValid;
  end

  always_comb begin
    bankRegView                      = '0;
    bankRegView[BANKSEL_W-1:0]       = bankQ;
    bankRegView[RDIDX_LSB +: IDX_W]  = rdIdxQ;
    bankRegView[NOINC_BIT]           = noIncQ;
    bankRegView[INVAL_BIT]           = !bankValid;
  end

  assign noInc = noIncQ;
endmodule

// File: rtl/brp_datapath.sv
module brp_datapath
  import brp_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctrlS,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               blitDone,
  output logic [DATA_W-1:0]  rdWord,
  output logic [DATA_W-1:0]  statusWord,
  output logic               blitStart
);
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [DATA_W-1:0]     regFile [NUM_BANKS][NUM_IDX];
  logic [DATA_W-1:0]     statusQ;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  hitStatus;
  logic                  hitStart;
  logic                  wrEn;

  assign bankIdx   = ctrlS.bank[BANK_IDX_W-1:0];
  assign hitStatus = (ctrlS.bank == '0) && (ctrlS.wrIdx == '0);
  assign wrEn      = ctrlS.dataWe && ctrlS.bankValid && !hitStatus;
  assign hitStart  = wrEn && (ctrlS.bank == BANKSEL_W'(1)) && (ctrlS.wrIdx == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int i = 0; i < NUM_IDX; i++)
          regFile[b][i] <= '0;
    end else begin
      if (blitDone && !hitStart)
        regFile[1][0][START_BIT] <= 1'b0;
      if (wrEn)
        regFile[bankIdx][ctrlS.wrIdx] <= ctrlS.wrVal;
    end
  end

  function automatic logic [DATA_W-1:0] buildStatus(input logic [NUM_IRQ-1:0] req);
    logic [DATA_W-1:0] s;
    s       = '0;
    s[0]    = |req;
    s[6:1]  = req[5:0];
    s[7]    = |req[9:6];
    s[11:8] = req[9:6];
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= buildStatus(irqReq);
  end

  always_comb begin
    if (!ctrlS.bankValid)
      rdWord = '0;
    else if (ctrlS.bank == '0 && ctrlS.rdIdx == '0)
      rdWord = statusQ;
    else
      rdWord = regFile[bankIdx][ctrlS.rdIdx];
  end

  assign statusWord = statusQ;
  assign blitStart  = regFile[1][0][START_BIT];
endmodule

// File: rtl/banked_reg_port.sv
module banked_reg_port
  import brp_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic               hostAddr,
  input  logic [HOST_W-1:0]  hostWdata,
  output logic [HOST_W-1:0]  hostRdata,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               blitDone,
  output logic               blitStart
);
  ctrlStrobe_t       ctrlS;
  logic [HOST_W-1:0] bankRegView;
  logic              noInc;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] statusWord;

  brp_ctrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .ctrlS(ctrlS), .bankRegView(bankRegView), .noInc(noInc)
  );

  brp_datapath #(.NUM_BANKS(NUM_BANKS)) dp_i (
    .clk(clk), .rstN(rstN), .ctrlS(ctrlS), .irqReq(irqReq),
    .blitDone(blitDone), .rdWord(rdWord), .statusWord(statusWord),
    .blitStart(blitStart)
  );

  assign hostRdata = hostAddr ? {{(HOST_W-DATA_W){1'b0}}, rdWord} : bankRegView;
endmodule

// File: rtl/brp_checker.sv
module brp_checker
  import brp_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWr,
  input logic               hostRd,
  input logic               hostAddr,
  input logic [HOST_W-1:0]  hostWdata,
  input logic [HOST_W-1:0]  hostRdata,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic               blitDone,
  input logic               blitStart,
  input logic [IDX_W-1:0]   rdIdx,
  input logic               noInc,
  input logic               bankValid,
  input logic [DATA_W-1:0]  statusWord
);
  // Data-port read advances the index by one, wrapping
  assert_rd_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr && !noInc) |=> (rdIdx == $past(rdIdx) + 1'b1));

  // Index is held when auto-increment is off and the control word is untouched
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr && noInc && !(hostWr && !hostAddr)) |=> $stable(rdIdx));

  // Missing bank reads back as zero
  assert_invalid_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr && !bankValid) |-> (hostRdata == '0));

  // Status summary bit follows all request lines one cycle later
  assert_status_any_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusWord[0] == |$past(irqReq)));

  // Status high-group OR bit
  assert_status_group_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusWord[7] == |$past(irqReq[9:6])));

  // Done pulse without a data write drops the start flag
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (blitDone && !(hostWr && hostAddr)) |=> !blitStart);

  // Start flag only rises on a host data write
  assert_start_by_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blitStart) |-> $past(hostWr && hostAddr));
endmodule

bind banked_reg_port brp_checker #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
  .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
  .irqReq(irqReq), .blitDone(blitDone), .blitStart(blitStart),
  .rdIdx(ctrlS.rdIdx), .noInc(noInc), .bankValid(ctrlS.bankValid),
  .statusWord(statusWord)
);

// File: tb/banked_reg_port_tb_top.sv
`timescale 1ns/1ps
module banked_reg_port_tb_top;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWr, hostRd, hostAddr;
  logic [15:0] hostWdata;
  logic [15:0] hostRdata;
  logic [9:0]  irqReq;
  logic        blitDone;
  logic        blitStart;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model
  logic [11:0] memM [4][16];
  logic [7:0]  bankM;
  logic [3:0]  idxM;
  logic        noIncM;
  logic [11:0] statM;

  always #4 clk = ~clk;

  banked_reg_port #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .irqReq(irqReq), .blitDone(blitDone), .blitStart(blitStart)
  );

  function automatic logic [11:0] statusOf(input logic [9:0] r);
    logic [11:0] s;
    s = '0;
    s[0] = |r;
    for (int k = 0; k < 6; k++) s[k+1] = r[k];
    s[7] = |r[9:6];
    for (int k = 0; k < 4; k++) s[k+8] = r[k+6];
    return s;
  endfunction

  function automatic logic [15:0] expRead(input logic addr);
    logic valid;
    valid = bankM < NB;
    if (!addr) return {2'b00, !valid, noIncM, idxM, bankM};
    if (!valid) return 16'h0;
    if (bankM == 0 && idxM == 0) return {4'h0, statM};
    return {4'h0, memM[bankM][idxM]};
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic wr, input logic rd, input logic addr,
                      input logic [15:0] wd, input logic [9:0] irq,
                      input logic done, input string req);
    logic hitStart;
    @(negedge clk);
    hostWr = wr; hostRd = rd; hostAddr = addr; hostWdata = wd;
    irqReq = irq; blitDone = done;
    #1;
    if (rd) check(hostRdata, expRead(addr), req);
    @(posedge clk);
    hitStart = 1'b0;
    if (wr && !addr) begin
      bankM = wd[7:0]; idxM = wd[11:8]; noIncM = wd[12];
    end
    if (wr && addr && bankM < NB && !(bankM == 0 && wd[15:12] == 0)) begin
      hitStart = (bankM == 1 && wd[15:12] == 0);
    end
    if (done && !hitStart) memM[1][0][11] = 1'b0;
    if (wr && addr && bankM < NB && !(bankM == 0 && wd[15:12] == 0))
      memM[bankM][wd[15:12]] = wd[11:0];
    if (rd && addr && !noIncM) idxM = idxM + 1'b1;
    statM = statusOf(irq);
    #1;
    check({15'h0, blitStart}, {15'h0, memM[1][0][11]}, "R9 blitStart");
  endtask

  task automatic wrCtrl(input logic [15:0] v);
    doOp(1, 0, 0, v, 10'h0, 0, "R2");
  endtask
  task automatic wrData(input logic [3:0] idx, input logic [11:0] v, input string req);
    doOp(1, 0, 1, {idx, v}, 10'h0, 0, req);
  endtask
  task automatic rdData(input string req);
    doOp(0, 1, 1, 16'h0, 10'h0, 0, req);
  endtask
  task automatic rdCtrl(input string req);
    doOp(0, 1, 0, 16'h0, 10'h0, 0, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    hostWr = 0; hostRd = 0; hostAddr = 0; hostWdata = '0;
    irqReq = '0; blitDone = 0; rstN = 0;
    for (int b = 0; b < 4; b++) for (int i = 0; i < 16; i++) memM[b][i] = '0;
    bankM = 0; idxM = 0; noIncM = 0; statM = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: reset state
    #1;
    check(hostRdata, 16'h0000, "R1 ctrl word");
    check({15'h0, blitStart}, 16'h0, "R1 blitStart");
    for (int b = 0; b < NB; b++) begin
      wrCtrl({8'h00, 8'(b)});
      for (int i = 0; i < 16; i++) rdData("R1 regs");
    end

    // R2: field layout, upper bits read zero
    wrCtrl(16'hD502);
    rdCtrl("R2 readback");
    // R3: invalid flag
    wrCtrl(16'h2003);
    rdCtrl("R3 bank 3 flagged");
    wrCtrl(16'h2002);
    rdCtrl("R3 bank 2 not flagged");

    // R4/R5: writes with embedded index, streaming reads with wrap
    wrCtrl(16'h0E02);
    wrData(4'hE, 12'hABC, "R4");
    wrData(4'hF, 12'h123, "R4");
    wrData(4'h0, 12'h456, "R4");
    rdData("R4 idx14");
    rdData("R5 idx15");
    rdData("R5 wrap to 0");
    rdCtrl("R5 index after wrap");
    // R5: hold when increment disabled
    wrCtrl(16'h1F02);
    rdData("R5 hold a");
    rdData("R5 hold b");
    rdCtrl("R5 index held");

    // R6: writes to nonexistent banks ignored
    wrCtrl(16'h0003);
    wrData(4'h5, 12'hFFF, "R6");
    rdData("R6 read zero");
    wrCtrl(16'h0081);
    wrData(4'h5, 12'hEEE, "R6");
    rdData("R6 read zero high bank");
    for (int b = 0; b < NB; b++) begin
      wrCtrl({8'h15, 8'(b)});
      rdData("R6 bank untouched");
    end

    // R7: status layout
    wrCtrl(16'h1000);
    doOp(0, 0, 1, 16'h0, 10'b00_1000_0000, 0, "R7");
    rdData("R7 irq8");
    doOp(0, 0, 1, 16'h0, 10'b00_0000_0010, 0, "R7");
    rdData("R7 blit irq");
    doOp(0, 0, 1, 16'h0, 10'b10_0000_0001, 0, "R7");
    rdData("R7 irq1 and irq10");
    // R8: status write ignored
    wrData(4'h0, 12'hFFF, "R8");
    rdData("R8 status unchanged");

    // R9: blit start and done
    wrCtrl(16'h1001);
    wrData(4'h0, 12'h805, "R9");
    rdData("R9 start set");
    doOp(0, 0, 1, 16'h0, 10'h0, 1, "R9 done");
    rdData("R9 start cleared, low bits kept");
    wrData(4'h0, 12'h801, "R9");
    doOp(1, 0, 1, 16'h0803, 10'h0, 1, "R9 write beats done");
    rdData("R9 write beats done");

    // random mix
    seed = 32'd12345;
    void'($urandom(seed));
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      logic [15:0] w;
      logic [9:0] irq;
      op = $urandom_range(0, 9);
      w  = 16'($urandom());
      irq = 10'($urandom());
      if (op < 2) begin
        w[7:0] = ($urandom_range(0, 7) == 0) ? w[7:0] : 8'($urandom_range(0, 3));
        doOp(1, 0, 0, w, irq, ($urandom_range(0, 7) == 0), "R2 random ctrl");
      end else if (op < 5) begin
        doOp(1, 0, 1, w, irq, ($urandom_range(0, 7) == 0), "R4 random write");
      end else if (op < 9) begin
        doOp(0, 1, 1, w, irq, ($urandom_range(0, 7) == 0), "R4 random read");
      end else begin
        doOp(0, 1, 0, w, irq, 0, "R3 random ctrl read");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule